// File: doc/BRIEF.md
# Configurable frame-length SPI engine

This block is a single SPI shift engine driven through a four-register read/write port: a control register, a data register, a configuration register and a clock-rate register. It works as a bus master, where it generates the serial clock from the system clock, or as a slave, where it follows an external serial clock while its slave-select input is low. Clock polarity and clock phase are selectable. In master mode a transfer starts when software writes the data register, and it carries a programmable number of bits from 1 to 8.

Data moves most significant bit first. A short master frame sends the upper bits of the written byte, and received bits fill the data register from the least significant bit upward. A live bit counter can be read from the configuration register while a frame is in progress. A sticky completion flag, which is also brought out as a pin, marks the end of each frame. Software can check a collision flag that is set when the data register is written during a frame.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset the control register reads 0x00 (slave mode, no flags), the configuration register reads 0x07, the data register reads 0x00, and sck_o is low.
- R2: In master mode each half period of SCK lasts rate+1 system clocks, where rate is the clock-rate register (address 3). The first SCK edge comes rate+1 clocks after the cycle in which the data write is taken.
- R3: While no master frame is running, sck_o equals the polarity bit (configuration bit 6). 0 gives idle low and 1 gives idle high.
- R4: With phase bit (configuration bit 7) at 0, data is sampled on the first SCK edge of each bit and the next bit is presented on the second edge. With phase at 1, a bit is presented on the first edge (except for the first bit, which is already presented when the frame starts) and sampled on the second edge.
- R5: In master mode, configuration bits 2:0 holding value f give frames of f+1 bits. The transmitted bits are data bits 7 down to 7-f. The data register (address 1) then reads the received bits in its low f+1 positions, first-received highest, with the upper bits 0.
- R6: In slave mode every frame is 8 bits whatever bits 2:0 hold. The slave samples mosi_i, presents the loaded byte on miso_o MSB first, and its inputs pass through a synchronizer.
- R7: Configuration bits 5:3 read the number of bits sampled so far in the current frame, modulo 8. They read 0 once the frame ends, and writes to them are ignored.
- R8: Control bit 1 (done) and the done_o pin are set at the end of every frame. They stay set until a control write (address 0) with bit 1 at 0. A control write with bit 1 at 1 leaves them set.
- R9: A data write during a frame sets control bit 2 (collision). It changes neither the bits shifted out nor the received result. The collision bit is cleared by a control write with bit 2 at 0.
- R10: In slave mode, raising nss_i before the eighth bit clears the bit counter and drops the partial word. The data register and done stay unchanged, and the next frame is received normally after the byte is reloaded.
- R11: Control bit 3 (busy) is 1 in master mode from the clock after the starting data write until the end of the frame, which lasts 2×bits×(rate+1) clocks. Control bit 0 selects master (1) or slave (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 configuration, 3 clock rate |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_i | input | 1 | Master data in |
| nss_i | input | 1 | Slave select, active low |
| done_o | output | 1 | Sticky frame-complete flag |

## Verification
Master frames are run with all four polarity and phase pairings and with frame lengths of 8, 5, 3 and 1 bits at several clock-rate values. A reference model compares SCK, MOSI, busy, done and the bit counter on every clock, so an error of one cycle in the divider or of one edge in the phase handling shows up where it happens. Distinct transmit and receive bytes tell apart errors of bit order, of alignment in short frames and of mixing up the two directions. Slave frames are run with a short frame size programmed to show that it is ignored, with both phases, and with an early slave-select release followed by a clean frame, which tells a dropped partial word apart from one that leaks into the next result.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   typedef enum logic [1:0] {
      RSEL_CTRL = 2'd0,
      RSEL_DATA = 2'd1,
      RSEL_CFG  = 2'd2,
      RSEL_RATE = 2'd3
   } rsel_e;

   localparam int CTL_MASTER = 0;
   localparam int CTL_DONE   = 1;
   localparam int CTL_WCOL   = 2;
   localparam int CTL_BUSY   = 3;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("spi_fe_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_fe_clkdiv.sv
module spi_fe_clkdiv #(
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] rate,
   output logic            tick,
   output logic [DIVW-1:0] count_o
);
   logic [DIVW-1:0] cnt_q;

   assign tick    = run && (cnt_q == rate);
   assign count_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter #(
   parameter int DW = 8,
   localparam int CW = $clog2(DW),
   localparam int EW = CW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] load_word,
   input  logic          clear,
   input  logic          edge_i,
   input  logic          cpha,
   input  logic [CW-1:0] last_bit,
   input  logic          din,
   output logic          sout,
   output logic          tog,
   output logic [CW-1:0] pos,
   output logic          frame_end,
   output logic [DW-1:0] rx_word
);
   logic [DW-1:0] tx_q, rx_q, rx_nx;
   logic [EW-1:0] e_q;
   logic [CW-1:0] cnt_q;
   logic          tog_q;
   logic          leading, sample_now, shift_now;

   assign leading    = ~e_q[0];
   assign sample_now = edge_i && (cpha ? !leading : leading);
   assign shift_now  = edge_i && (cpha ? (leading && (e_q != '0)) : !leading);
   assign frame_end  = edge_i && (e_q == {last_bit, 1'b1});
   assign rx_nx      = sample_now ? {rx_q[DW-2:0], din} : rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         rx_q  <= '0;
         e_q   <= '0;
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else if (start) begin
         tx_q  <= load_word;
         rx_q  <= '0;
         e_q   <= '0;
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else if (clear) begin
         rx_q  <= '0;
         e_q   <= '0;
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else if (edge_i) begin
         if (shift_now) tx_q <= {tx_q[DW-2:0], 1'b0};
         rx_q  <= rx_nx;
         tog_q <= ~tog_q;
         if (frame_end) begin
            e_q   <= '0;
            cnt_q <= '0;
         end else begin
            e_q <= e_q + 1'b1;
            if (sample_now) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sout    = tx_q[DW-1];
   assign tog     = tog_q;
   assign pos     = cnt_q;
   assign rx_word = rx_nx;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
   parameter int DW          = 8,
   parameter int DIVW        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    reg_addr,
   input  logic          reg_wr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          sck_o,
   input  logic          sck_i,
   output logic          mosi_o,
   input  logic          mosi_i,
   output logic          miso_o,
   input  logic          miso_i,
   input  logic          nss_i,
   output logic          done_o
);
   import spi_fe_pkg::*;

   localparam int CW     = $clog2(DW);
   localparam int POS_LO = CW;
   localparam int POL_B  = 2 * CW;
   localparam int PHA_B  = 2 * CW + 1;

   generate
      if (DW != (1 << CW) || (2 * CW + 2) > DW || DW < 4) begin : g_bad_width
         $error("spi_frame_engine: DW must be a power of two with room for the config fields");
      end
      if (DIVW > DW || DIVW < 1) begin : g_bad_div
         $error("spi_frame_engine: DIVW must fit in one register");
      end
   endgenerate

   logic          master_q, done_q, wcol_q, cpha_q, cpol_q, mbusy_q;
   logic [CW-1:0] fsize_q;
   logic [DIVW-1:0] rate_q, div_cnt;
   logic [DW-1:0] rxbuf_q, rx_word;
   logic          sck_s, mosi_s, nss_s, sck_d_q;
   logic          busy, ctl_wr, data_wr, cfg_wr, rate_wr, start, clear;
   logic          tick, edge_sel, frame_end, sout, tog, din;
   logic [CW-1:0] bitpos, last_bit;

   spi_fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({nss_i, mosi_i, sck_i}),
      .q({nss_s, mosi_s, sck_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d_q <= 1'b0;
      else        sck_d_q <= sck_s;
   end

   assign ctl_wr   = reg_wr && (reg_addr == RSEL_CTRL);
   assign data_wr  = reg_wr && (reg_addr == RSEL_DATA);
   assign cfg_wr   = reg_wr && (reg_addr == RSEL_CFG);
   assign rate_wr  = reg_wr && (reg_addr == RSEL_RATE);
   assign busy     = master_q ? mbusy_q : ~nss_s;
   assign start    = data_wr && !busy;
   assign clear    = ~master_q & nss_s;
   assign edge_sel = master_q ? tick : (~nss_s & (sck_s ^ sck_d_q));
   assign last_bit = master_q ? fsize_q : '1;
   assign din      = master_q ? miso_i : mosi_s;

   spi_fe_clkdiv #(.DIVW(DIVW)) u_div (
      .clk(clk), .rst_n(rst_n), .run(mbusy_q), .rate(rate_q),
      .tick(tick), .count_o(div_cnt)
   );

   spi_fe_shifter #(.DW(DW)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .load_word(reg_wdata),
      .clear(clear), .edge_i(edge_sel), .cpha(cpha_q), .last_bit(last_bit),
      .din(din), .sout(sout), .tog(tog), .pos(bitpos),
      .frame_end(frame_end), .rx_word(rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         done_q   <= 1'b0;
         wcol_q   <= 1'b0;
         cpha_q   <= 1'b0;
         cpol_q   <= 1'b0;
         fsize_q  <= '1;
         rate_q   <= '0;
         rxbuf_q  <= '0;
         mbusy_q  <= 1'b0;
      end else begin
         if (ctl_wr) master_q <= reg_wdata[CTL_MASTER];
         if (frame_end)   done_q <= 1'b1;
         else if (ctl_wr) done_q <= done_q & reg_wdata[CTL_DONE];
         if (data_wr && busy) wcol_q <= 1'b1;
         else if (ctl_wr)     wcol_q <= wcol_q & reg_wdata[CTL_WCOL];
         if (cfg_wr) begin
            cpha_q  <= reg_wdata[PHA_B];
            cpol_q  <= reg_wdata[POL_B];
            fsize_q <= reg_wdata[CW-1:0];
         end
         if (rate_wr) rate_q <= reg_wdata[DIVW-1:0];
         if (frame_end) rxbuf_q <= rx_word;
         if (start && master_q) mbusy_q <= 1'b1;
         else if (frame_end)    mbusy_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RSEL_CTRL: begin
            reg_rdata[CTL_MASTER] = master_q;
            reg_rdata[CTL_DONE]   = done_q;
            reg_rdata[CTL_WCOL]   = wcol_q;
            reg_rdata[CTL_BUSY]   = busy & master_q;
         end
         RSEL_DATA: reg_rdata = rxbuf_q;
         RSEL_CFG: begin
            reg_rdata[PHA_B]             = cpha_q;
            reg_rdata[POL_B]             = cpol_q;
            reg_rdata[POS_LO+CW-1:POS_LO] = bitpos;
            reg_rdata[CW-1:0]            = fsize_q;
         end
         default: reg_rdata[DIVW-1:0] = rate_q;
      endcase
   end

   assign sck_o  = cpol_q ^ (master_q & tog);
   assign mosi_o = master_q & sout;
   assign miso_o = ~master_q & sout;
   assign done_o = done_q;
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
   parameter int DW   = 8,
   parameter int DIVW = 8,
   parameter int CW   = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            master,
   input logic            busy,
   input logic            sck_o,
   input logic            cpol,
   input logic            done,
   input logic            wcol,
   input logic            ctl_wr,
   input logic            data_wr,
   input logic            cfg_wr,
   input logic            keep_done,
   input logic [CW-1:0]   pos,
   input logic            nss_s,
   input logic [DIVW-1:0] div_cnt,
   input logic [DIVW-1:0] rate,
   input logic            frame_end
);
   // R2: no SCK change until the divider reaches the rate value
   a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      master && busy && (div_cnt != rate) && !cfg_wr && !ctl_wr |=> $stable(sck_o));

   // R3: idle master clock sits at the polarity level
   a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      master && !busy |-> sck_o == cpol);

   // R8: completion flag holds until cleared by software
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done && !(ctl_wr && !keep_done) |=> done);

   // R9: data write during a frame raises the collision flag
   a_r9_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && busy |=> wcol);

   // R10: slave deselect clears the bit counter
   a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !master && $rose(nss_s) |=> pos == '0);

   // R11: master frames end only while busy
   a_r11_end_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && master |-> busy);
endmodule

bind spi_frame_engine spi_fe_chk #(.DW(DW), .DIVW(DIVW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .master(master_q), .busy(busy), .sck_o(sck_o),
   .cpol(cpol_q), .done(done_q), .wcol(wcol_q), .ctl_wr(ctl_wr),
   .data_wr(data_wr), .cfg_wr(cfg_wr), .keep_done(reg_wdata[1]),
   .pos(bitpos), .nss_s(nss_s), .div_cnt(div_cnt), .rate(rate_q),
   .frame_end(frame_end)
);

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sck_o, mosi_o, miso_o, done_o;
   logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, nss_i = 1'b1;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   spi_frame_engine uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o),
      .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o),
      .miso_i(miso_i), .nss_i(nss_i), .done_o(done_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Behavioural master model: edge count from elapsed clocks, compared every clock
   task automatic run_master(input bit cpol, input bit cpha, input int n, input int dv,
                             input logic [7:0] data, input logic [7:0] pat, input bit inject);
      logic [7:0] v;
      int h, samples, shifts;
      wr(2'd2, {cpha, cpol, 3'b000, 3'(n - 1)});
      wr(2'd3, 8'(dv));
      wr(2'd0, 8'h01);
      miso_i = pat[7];
      @(negedge clk);
      reg_addr = 2'd1; reg_wdata = data; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      for (int k = 0; k < 10000; k++) begin
         h = k / (dv + 1);
         if (h > 2 * n) h = 2 * n;
         samples = cpha ? h / 2 : (h + 1) / 2;
         shifts  = cpha ? ((h == 0) ? 0 : (h - 1) / 2) : h / 2;
         check("R2/R3/R4 sck_o", sck_o, cpol ^ h[0]);
         check("R4/R5 mosi_o", mosi_o, (shifts < 8) ? data[7 - shifts] : 1'b0);
         rd(2'd0, v);
         check("R11 busy bit", v[3], (h < 2 * n));
         check("R8 done_o", done_o, (h == 2 * n));
         rd(2'd2, v);
         check("R7 bit counter", v[5:3], (h == 2 * n) ? 0 : samples % 8);
         miso_i = (samples < 8) ? pat[7 - samples] : 1'b0;
         if (inject && k == 2) begin
            reg_addr = 2'd1; reg_wdata = ~data; reg_wr = 1'b1;
         end
         if (h == 2 * n) break;
         @(negedge clk);
         reg_wr = 1'b0;
      end
      rd(2'd1, v);
      check("R5 received word", v, pat >> (8 - n));
      rd(2'd0, v);
      check("R9 collision bit", v[2], inject);
      wait_clks(3);
      check("R8 done held", done_o, 1'b1);
   endtask

   task automatic run_slave(input bit cpol, input bit cpha, input logic [2:0] fs,
                            input logic [7:0] txd, input logic [7:0] pat, input int stop_at);
      logic [7:0] v, prev;
      nss_i = 1'b1;
      sck_i = cpol;
      wr(2'd2, {cpha, cpol, 3'b000, fs});
      wr(2'd0, 8'h00);
      wait_clks(6);
      wr(2'd1, txd);
      rd(2'd1, prev);
      nss_i = 1'b0;
      wait_clks(6);
      for (int i = 0; i < stop_at; i++) begin
         if (!cpha) begin
            mosi_i = pat[7 - i];
            wait_clks(6);
            check("R6 slave miso_o", miso_o, txd[7 - i]);
            sck_i = ~cpol;
            wait_clks(6);
            sck_i = cpol;
            wait_clks(6);
         end else begin
            sck_i = ~cpol;
            wait_clks(6);
            check("R4/R6 slave miso_o", miso_o, txd[7 - i]);
            mosi_i = pat[7 - i];
            wait_clks(6);
            sck_i = cpol;
            wait_clks(6);
         end
         if (i == 2 && stop_at < 8) begin
            rd(2'd2, v);
            check("R7 slave live counter", v[5:3], 3);
         end
      end
      nss_i = 1'b1;
      wait_clks(6);
      if (stop_at >= 8) begin
         check("R6 slave done", done_o, 1'b1);
         rd(2'd1, v);
         check("R6 slave 8-bit word", v, pat);
      end else begin
         check("R10 no done on abort", done_o, 1'b0);
         rd(2'd2, v);
         check("R10 counter cleared", v[5:3], 0);
         rd(2'd1, v);
         check("R10 partial dropped", v, prev);
      end
   endtask

   initial begin
      logic [7:0] v;
      wait_clks(4);
      rst_n = 1'b1;
      wait_clks(1);
      rd(2'd2, v); check("R1 config reset", v, 8'h07);
      rd(2'd0, v); check("R1 control reset", v, 8'h00);
      rd(2'd1, v); check("R1 data reset", v, 8'h00);
      check("R1 sck idle", sck_o, 1'b0);
      check("R1 done_o reset", done_o, 1'b0);

      wr(2'd2, 8'h3F);
      rd(2'd2, v); check("R7 counter write ignored", v, 8'h07);

      run_master(1'b0, 1'b0, 8, 0, 8'hA5, 8'h3C, 1'b0);
      run_master(1'b1, 1'b1, 8, 2, 8'h96, 8'hC3, 1'b1);
      run_master(1'b0, 1'b1, 5, 1, 8'hB4, 8'hE8, 1'b0);
      run_master(1'b1, 1'b0, 1, 3, 8'h80, 8'h80, 1'b0);
      run_master(1'b0, 1'b0, 3, 0, 8'h6A, 8'h5A, 1'b0);

      wr(2'd0, 8'h03);
      check("R8 done kept by write of 1", done_o, 1'b1);
      wr(2'd0, 8'h01);
      check("R8 done cleared by write of 0", done_o, 1'b0);
      rd(2'd0, v); check("R11 master bit readback", v[0], 1'b1);

      run_slave(1'b0, 1'b0, 3'd3, 8'h5C, 8'hA7, 8);
      run_slave(1'b1, 1'b1, 3'd7, 8'h3E, 8'h81, 8);
      run_slave(1'b0, 1'b0, 3'd7, 8'hF0, 8'h55, 3);
      run_slave(1'b0, 1'b1, 3'd7, 8'h0F, 8'hC6, 8);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule